// File: doc/BRIEF.md
# Serial Wiper Register Port

This block is the write side of a digitally controlled potentiometer's wiper register. It takes a three-wire serial stream: an active-low frame strobe, a serial clock and a data line. It holds a 10-bit wiper setting that the analog part downstream would use. All three serial pins are oversampled in the system clock domain. A frame opens when the strobe goes low. Each falling edge of the serial clock inside the frame shifts one bit into a 16-bit register, most significant bit first. The frame takes effect only when the strobe rises after exactly sixteen falling edges. A shorter or longer frame is thrown away.

The word carries a command field and a data field. A write command replaces the wiper. A read command loads the current wiper into the shift register, so the next frame clocks it out. The serial output always presents the bit about to leave the shift register, so several devices can be chained. A ready flag drops briefly after each accepted read or write. A rising edge on the reload pin restores the wiper from a stored value, or from midscale when nothing has been stored.

Top module: `pot_serial_if`

## Requirements
- R1: After system reset the wiper is 10'h200, ready is 1 and sdo is 0.
- R2: In a 16-bit frame, the bit captured on the first sclk falling edge after sync_n falls is word bit 15. Bits [13:10] are the command and bits [9:0] the data. Bits [15:14] have no effect.
- R3: A frame with command 1 (write) and exactly 16 sclk falling edges sets the wiper to the data field when sync_n rises.
- R4: When sync_n rises after fewer than 16 sclk falling edges, the wiper keeps its value and ready stays 1.
- R5: When sync_n rises after more than 16 sclk falling edges, the wiper keeps its value and ready stays 1.
- R6: A complete frame whose command is neither 1 nor 2 leaves the wiper unchanged and ready at 1.
- R7: After a complete frame with command 1 or 2 is accepted, ready is 0 for exactly two system clock cycles, then returns to 1.
- R8: At frame start and on each sclk rising edge inside a frame, sdo takes bit 15 of the shift register. The next frame therefore clocks out the previous complete frame's 16 bits, MSB first.
- R9: After a complete read frame (command 2), the shift register holds {6'b0, wiper}, and the next frame clocks this value out on sdo.
- R10: A rising edge on reload sets the wiper to nv_word when nv_valid is 1, and to 10'h200 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idle high |
| sync_n | input | 1 | Frame strobe, active low |
| sdi | input | 1 | Serial data in |
| reload | input | 1 | Wiper reload request, acts on its rising edge |
| nv_valid | input | 1 | Stored wiper value present |
| nv_word | input | 10 | Stored wiper value |
| wiper | output | 10 | Current wiper setting |
| ready | output | 1 | Low while a read or write completes |
| sdo | output | 1 | Serial data out for chaining and readback |

## Verification
The bench targets frames closed after 10 and after 17 falling edges. A design that counted loosely, or that committed on whatever had arrived, would move the wiper on those frames. Unknown command codes and set upper bits are also sent, to catch a decoder that treats any complete frame as a write. Readback and chaining are checked by collecting sdo just before each falling edge of the following frame. A one-bit slip, or an sdo updated on the wrong edge, would scramble that word. The width of the ready dip, and both reload sources, are compared every clock against a behavioural model.

// File: rtl/pot_pkg.sv
package pot_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP   = 4'd0,
    CMD_WRITE = 4'd1,
    CMD_READ  = 4'd2
  } cmd_e;

  localparam int PIN_SCLK   = 0;
  localparam int PIN_SYNC   = 1;
  localparam int PIN_SDI    = 2;
  localparam int PIN_RELOAD = 3;
  localparam int PIN_COUNT  = 4;
  localparam logic [PIN_COUNT-1:0] PIN_IDLE = 4'b0011;
endpackage

// File: rtl/pot_sync_edge.sv
module pot_sync_edge #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= IDLE;
      prev_q <= IDLE;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign level = stage_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
endmodule

// File: rtl/pot_frame_shifter.sv
module pot_frame_shifter
  import pot_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int WIPER_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               sync_rise,
  input  logic               sync_fall,
  input  logic               sdi,
  input  logic [WIPER_W-1:0] rb_data,
  output logic               commit,
  output logic [CMD_W-1:0]   cmd,
  output logic [WIPER_W-1:0] data,
  output logic               sdo
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] shreg_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  open_q, commit_q, sdo_q;
  logic [CMD_W-1:0]      cmd_q;
  logic [WIPER_W-1:0]    data_q;
  logic [CMD_W-1:0]      sh_cmd;

  assign sh_cmd = shreg_q[WIPER_W +: CMD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q  <= '0;
      cnt_q    <= '0;
      open_q   <= 1'b0;
      commit_q <= 1'b0;
      sdo_q    <= 1'b0;
      cmd_q    <= '0;
      data_q   <= '0;
    end else begin
      commit_q <= 1'b0;
      if (sync_fall) begin
        open_q <= 1'b1;
        cnt_q  <= '0;
        sdo_q  <= shreg_q[FRAME_BITS-1];
      end else if (sync_rise) begin
        open_q <= 1'b0;
        if (open_q && cnt_q == FULL) begin
          commit_q <= 1'b1;
          cmd_q    <= sh_cmd;
          data_q   <= shreg_q[WIPER_W-1:0];
          if (sh_cmd == CMD_READ) shreg_q <= FRAME_BITS'(rb_data);
        end
      end else if (open_q && sclk_fall) begin
        shreg_q <= {shreg_q[FRAME_BITS-2:0], sdi};
        if (cnt_q != OVER) cnt_q <= cnt_q + 1'b1;
      end else if (open_q && sclk_rise) begin
        sdo_q <= shreg_q[FRAME_BITS-1];
      end
    end
  end

  assign commit = commit_q;
  assign cmd    = cmd_q;
  assign data   = data_q;
  assign sdo    = sdo_q;

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst)
    commit_q |=> !commit_q); // R3
  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= OVER); // R5
  AST_SDO_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!open_q && !sync_fall) |=> $stable(sdo_q)); // R8
  AST_COMMIT_CLOSES: assert property (@(posedge clk) disable iff (rst)
    commit_q |-> !open_q); // R4
endmodule

// File: rtl/pot_wiper_ctrl.sv
module pot_wiper_ctrl
  import pot_pkg::*;
#(
  parameter int WIPER_W = 10,
  parameter int BUSY_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit,
  input  logic [CMD_W-1:0]   cmd,
  input  logic [WIPER_W-1:0] data,
  input  logic               reload_rise,
  input  logic               nv_valid,
  input  logic [WIPER_W-1:0] nv_word,
  output logic [WIPER_W-1:0] wiper,
  output logic               ready
);
  localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  logic [WIPER_W-1:0] wiper_q;
  logic [BW-1:0]      busy_q;
  logic               ready_q;
  logic               is_wr, is_rd;

  assign is_wr = (cmd == CMD_WRITE);
  assign is_rd = (cmd == CMD_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      wiper_q <= MID;
      busy_q  <= '0;
      ready_q <= 1'b1;
    end else begin
      if (reload_rise) wiper_q <= nv_valid ? nv_word : MID;
      else if (commit && is_wr) wiper_q <= data;

      if (commit && (is_wr || is_rd)) begin
        busy_q  <= BW'(BUSY_CYCLES);
        ready_q <= 1'b0;
      end else if (busy_q != '0) begin
        busy_q  <= busy_q - 1'b1;
        ready_q <= (busy_q == BW'(1));
      end
    end
  end

  assign wiper = wiper_q;
  assign ready = ready_q;

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (commit && (is_wr || is_rd)) |=> !ready_q); // R7
  AST_READY_RECOVERS: assert property (@(posedge clk) disable iff (rst)
    (busy_q == BW'(1) && !commit) |=> ready_q); // R7
  AST_WIPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!reload_rise && !(commit && is_wr)) |=> $stable(wiper_q)); // R4
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    reload_rise |=> wiper_q == ($past(nv_valid) ? $past(nv_word) : MID)); // R10
endmodule

// File: rtl/pot_serial_if.sv
module pot_serial_if
  import pot_pkg::*;
#(
  parameter int WIPER_W = 10,
  parameter int FRAME_BITS = 16,
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk,
  input  logic               sync_n,
  input  logic               sdi,
  input  logic               reload,
  input  logic               nv_valid,
  input  logic [WIPER_W-1:0] nv_word,
  output logic [WIPER_W-1:0] wiper,
  output logic               ready,
  output logic               sdo
);
  logic [PIN_COUNT-1:0] pins, lvl, rise, fall;
  logic                 commit;
  logic [CMD_W-1:0]     cmd;
  logic [WIPER_W-1:0]   data;
  logic                 unused_edges;

  assign pins = {reload, sdi, sync_n, sclk};
  assign unused_edges = ^{rise[PIN_SDI], fall[PIN_SDI], fall[PIN_RELOAD],
                          lvl[PIN_SCLK], lvl[PIN_SYNC], lvl[PIN_RELOAD]};

  pot_sync_edge #(.W(PIN_COUNT), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .din(pins), .level(lvl), .rise(rise), .fall(fall)
  );

  pot_frame_shifter #(.FRAME_BITS(FRAME_BITS), .WIPER_W(WIPER_W)) u_shift (
    .clk(clk), .rst(rst),
    .sclk_rise(rise[PIN_SCLK]), .sclk_fall(fall[PIN_SCLK]),
    .sync_rise(rise[PIN_SYNC]), .sync_fall(fall[PIN_SYNC]),
    .sdi(lvl[PIN_SDI]), .rb_data(wiper),
    .commit(commit), .cmd(cmd), .data(data), .sdo(sdo)
  );

  pot_wiper_ctrl #(.WIPER_W(WIPER_W), .BUSY_CYCLES(BUSY_CYCLES)) u_wiper (
    .clk(clk), .rst(rst), .commit(commit), .cmd(cmd), .data(data),
    .reload_rise(rise[PIN_RELOAD]), .nv_valid(nv_valid), .nv_word(nv_word),
    .wiper(wiper), .ready(ready)
  );
endmodule

// File: tb/sim_pot_serial_if.sv
module sim_pot_serial_if;
  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b1, sync_n = 1'b1, sdi = 1'b0, reload = 1'b0, nv_valid = 1'b0;
  logic [9:0] nv_word = '0;
  logic [9:0] wiper;
  logic ready, sdo;

  always #10 clk = ~clk;

  pot_serial_if u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .sdi(sdi),
    .reload(reload), .nv_valid(nv_valid), .nv_word(nv_word),
    .wiper(wiper), .ready(ready), .sdo(sdo)
  );

  int checks = 0, fails = 0, lowcnt = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model, pins = {reload, sdi, sync_n, sclk}
  bit [3:0]  hist[$];
  bit [9:0]  mw, old_w, pdata;
  bit [15:0] msh;
  int        mbusy, mcnt, pcmd;
  bit        mready, msdo, mopen, pend, acc;
  bit [3:0]  pa, pb;

  always @(posedge clk) begin
    if (rst) begin
      mw = 10'h200; mbusy = 0; mready = 1; msh = '0; mcnt = 0;
      mopen = 0; pend = 0; msdo = 0; pcmd = 0; pdata = '0;
      hist = {4'b0011, 4'b0011, 4'b0011, 4'b0011};
    end else begin
      hist.push_front({reload, sdi, sync_n, sclk});
      pa = hist[3];
      pb = hist[2];
      void'(hist.pop_back());
      old_w = mw;
      acc = pend && (pcmd == 1 || pcmd == 2);
      if (pend && pcmd == 1) mw = pdata;
      if (acc) begin mbusy = 2; mready = 0; end
      else if (mbusy > 0) begin mbusy--; mready = (mbusy == 0); end
      pend = 0;
      if (!pa[3] && pb[3]) mw = nv_valid ? nv_word : 10'h200;
      if (pa[1] && !pb[1]) begin
        mopen = 1; mcnt = 0; msdo = msh[15];
      end else if (!pa[1] && pb[1]) begin
        if (mopen && mcnt == 16) begin
          pend = 1; pcmd = int'(msh[13:10]); pdata = msh[9:0];
          if (pcmd == 2) msh = {6'b0, old_w};
        end
        mopen = 0;
      end else if (mopen && pa[0] && !pb[0]) begin
        msh = {msh[14:0], pb[2]};
        if (mcnt < 17) mcnt++;
      end else if (mopen && !pa[0] && pb[0]) begin
        msdo = msh[15];
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R3/R10 wiper vs model", int'(wiper), int'(mw));
      chk("R7 ready vs model", int'(ready), int'(mready));
      chk("R8 sdo vs model", int'(sdo), int'(msdo));
      if (!ready) lowcnt++;
    end
  end

  task automatic frame(input logic [15:0] w, input int n, output logic [15:0] got);
    got = '0;
    lowcnt = 0;
    sync_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      got = {got[14:0], sdo};
      sdi = (i < 16) ? w[15-i] : 1'b0;
      sclk = 1'b0;
      repeat (6) @(negedge clk);
      sclk = 1'b1;
      repeat (6) @(negedge clk);
    end
    sync_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic pulse_reload();
    reload = 1'b1;
    repeat (6) @(negedge clk);
    reload = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    logic [15:0] got;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset wiper", int'(wiper), 'h200);
    chk("R1 reset ready", int'(ready), 1);
    chk("R1 reset sdo", int'(sdo), 0);

    frame(16'h0555, 16, got);                      // cmd 1, data 0x155
    chk("R3 write wiper", int'(wiper), 'h155);
    chk("R7 ready low cycles after write", lowcnt, 2);

    frame(16'h0000, 16, got);                      // cmd 0 shifts old word out
    chk("R8 daisy-chain word", int'(got), 'h0555);
    chk("R6 nop keeps wiper", int'(wiper), 'h155);
    chk("R6 nop ready stays high", lowcnt, 0);

    frame(16'h0800, 16, got);                      // cmd 2 read
    chk("R7 ready low cycles after read", lowcnt, 2);
    frame(16'h0000, 16, got);
    chk("R9 readback word", int'(got), 'h0155);

    frame(16'h07FF, 10, got);
    chk("R4 short frame keeps wiper", int'(wiper), 'h155);
    chk("R4 short frame ready", lowcnt, 0);

    frame(16'h06AA, 17, got);
    chk("R5 long frame keeps wiper", int'(wiper), 'h155);
    chk("R5 long frame ready", lowcnt, 0);

    frame(16'h14AA, 16, got);                      // cmd 5
    chk("R6 unknown cmd keeps wiper", int'(wiper), 'h155);

    frame(16'h07FF, 16, got);
    chk("R3 write max", int'(wiper), 'h3FF);
    frame(16'h0401, 16, got);
    chk("R2 msb-first order", int'(wiper), 'h001);
    frame(16'hC400, 16, got);                      // bits 15:14 set, cmd 1, data 0
    chk("R2 upper bits ignored", int'(wiper), 'h000);

    nv_valid = 1'b0;
    pulse_reload();
    chk("R10 reload midscale", int'(wiper), 'h200);
    nv_valid = 1'b1;
    nv_word = 10'h3A7;
    pulse_reload();
    chk("R10 reload stored", int'(wiper), 'h3A7);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end
endmodule